// File: doc/BRIEF.md
# Condition Bit to Register Setter

This block turns a single bit of a 32-bit condition register into a full-width general-register value. A 5-bit index picks the bit. Its upper three bits choose one of eight 4-bit condition fields, and its lower two bits choose one bit inside that field. Two control bits then select one of four variants. The reverse control tests for a clear bit instead of a set one. The negate control turns the 0/1 outcome into 0 or an all-ones mask.

The selection and shaping logic is combinational. The outcome is captured in one register stage, together with a valid flag, a write-enable and an illegal-instruction flag. A pipeline issues a request with `req_i`. One cycle later it gets either a result to write back, or an illegal flag when the feature-enable input is low. Register-file storage is outside this block.

Top module: `cbs_setter`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `wr_en_o` and `illegal_o` are low and `res_o` is zero.
- R2: Index bits [4:2] select condition field k, which sits at `cr_i[31-4k : 28-4k]`. Field 0 is the most significant nibble.
- R3: Index bits [1:0] select a bit inside the field. Value 0 selects the field's most significant bit and value 3 its least significant bit. Overall, index i tests `cr_i[31-i]`.
- R4: With `neg_i`=0 and `rev_i`=0, `res_o` is 1 when the tested bit is set and 0 when it is clear. Bits [63:1] are always zero.
- R5: With `neg_i`=0 and `rev_i`=1, `res_o` is 1 when the tested bit is clear and 0 when it is set.
- R6: With `neg_i`=1 and `rev_i`=0, `res_o` is all ones (64'hFFFF_FFFF_FFFF_FFFF) when the tested bit is set and 0 otherwise.
- R7: With `neg_i`=1 and `rev_i`=1, `res_o` is all ones when the tested bit is clear and 0 otherwise.
- R8: A request sampled on a clock edge makes `valid_o` high for exactly the following cycle, and the result appears in that same cycle.
- R9: A request with `en_i` low gives `illegal_o`=1, `wr_en_o`=0 and `res_o`=0 in the following cycle.
- R10: In a cycle that follows an edge with `req_i` low, `valid_o`, `wr_en_o` and `illegal_o` are low and `res_o` is zero.
- R11: Condition-register bits other than the tested one have no effect on `res_o`.
- R12: `wr_en_o` and `illegal_o` are never high together. `valid_o` is high exactly when one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| en_i | input | 1 | Feature enable; low makes a request illegal |
| cr_i | input | 32 | Condition register |
| bit_idx_i | input | 5 | Index of the tested bit |
| neg_i | input | 1 | Negate variant select |
| rev_i | input | 1 | Reverse variant select |
| res_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Result write-enable |
| illegal_o | output | 1 | Illegal-instruction flag |
| valid_o | output | 1 | Request completed this cycle |

## Verification
The assertions check the following on every cycle:
- The one-cycle request-to-valid timing.
- Idle outputs after a cycle with no request.
- Illegal handling when the feature is disabled.
- Mutual exclusion of write-enable and illegal.
- The shape of a written result: bits [63:1] are zero without negate, and the value is 0 or all ones with negate.

Only the bench scenarios can show that the right field and bit are chosen, that each variant gives the correct polarity, and that neighbouring condition bits are ignored. Those scenarios rely on known register patterns and hand-derived expected values.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int CR_W_DEF  = 32;
  localparam int FLD_W_DEF = 4;
  localparam int RES_W_DEF = 64;

  typedef enum logic [1:0] {
    VAR_PLAIN   = 2'b00,
    VAR_REV     = 2'b01,
    VAR_NEG     = 2'b10,
    VAR_NEG_REV = 2'b11
  } cbs_var_e;
endpackage

// File: rtl/cbs_fld_sel.sv
module cbs_fld_sel #(
  parameter int CR_W      = 32,
  parameter int FLD_W     = 4,
  localparam int NUM_FLD   = CR_W / FLD_W,
  localparam int FLD_IDX_W = $clog2(NUM_FLD),
  localparam int BIT_W     = $clog2(FLD_W)
) (
  input  logic [CR_W-1:0]      cr_i,
  input  logic [FLD_IDX_W-1:0] fld_idx_i,
  input  logic [BIT_W-1:0]     sub_idx_i,
  output logic                 bit_o
);
  localparam logic [FLD_W-1:0] TOP_MASK = {1'b1, {(FLD_W-1){1'b0}}};

  logic [FLD_W-1:0] fld [NUM_FLD];
  logic [FLD_W-1:0] fld_sel;
  logic [FLD_W-1:0] mask;

  // field 0 is the most significant nibble
  for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
    assign fld[k] = cr_i[CR_W-1-k*FLD_W -: FLD_W];
  end

  assign fld_sel = fld[fld_idx_i];
  assign mask    = TOP_MASK >> sub_idx_i;
  assign bit_o   = |(fld_sel & mask);
endmodule

// File: rtl/cbs_res_gen.sv
module cbs_res_gen
  import cbs_pkg::*;
#(
  parameter int RES_W = 64
) (
  input  logic             bit_i,
  input  logic             neg_i,
  input  logic             rev_i,
  output logic [RES_W-1:0] res_o
);
  cbs_var_e var_sel;
  logic     hit;

  assign var_sel = cbs_var_e'({neg_i, rev_i});

  always_comb begin
    hit = bit_i;
    unique case (var_sel)
      VAR_PLAIN:   hit = bit_i;
      VAR_REV:     hit = ~bit_i;
      VAR_NEG:     hit = bit_i;
      VAR_NEG_REV: hit = ~bit_i;
      default:     hit = bit_i;
    endcase
  end

  always_comb begin
    if (neg_i) res_o = {RES_W{hit}};                  // two's-complement of 0/1
    else       res_o = {{(RES_W-1){1'b0}}, hit};
  end
endmodule

// File: rtl/cbs_setter.sv
module cbs_setter
  import cbs_pkg::*;
#(
  parameter int CR_W  = CR_W_DEF,
  parameter int FLD_W = FLD_W_DEF,
  parameter int RES_W = RES_W_DEF,
  localparam int IDX_W = $clog2(CR_W),
  localparam int BIT_W = $clog2(FLD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             en_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             neg_i,
  input  logic             rev_i,
  output logic [RES_W-1:0] res_o,
  output logic             wr_en_o,
  output logic             illegal_o,
  output logic             valid_o
);
  logic             sel_bit;
  logic [RES_W-1:0] res_d;
  logic             do_wr;
  logic             do_ill;

  cbs_fld_sel #(
    .CR_W  (CR_W),
    .FLD_W (FLD_W)
  ) u_fld_sel (
    .cr_i      (cr_i),
    .fld_idx_i (bit_idx_i[IDX_W-1:BIT_W]),
    .sub_idx_i (bit_idx_i[BIT_W-1:0]),
    .bit_o     (sel_bit)
  );

  cbs_res_gen #(
    .RES_W (RES_W)
  ) u_res_gen (
    .bit_i (sel_bit),
    .neg_i (neg_i),
    .rev_i (rev_i),
    .res_o (res_d)
  );

  assign do_wr  = req_i & en_i;
  assign do_ill = req_i & ~en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      res_o     <= do_wr ? res_d : '0;
      wr_en_o   <= do_wr;
      illegal_o <= do_ill;
      valid_o   <= req_i;
    end
  end
endmodule

// File: rtl/cbs_setter_chk.sv
module cbs_setter_chk #(
  parameter int RES_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             en_i,
  input logic             neg_i,
  input logic [RES_W-1:0] res_o,
  input logic             wr_en_o,
  input logic             illegal_o,
  input logic             valid_o
);
  AST_REQ_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);                                                     // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !wr_en_o && !illegal_o && res_o == '0));        // R10
  AST_DISABLED_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !en_i) |=> (illegal_o && !wr_en_o && res_o == '0));           // R9
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, illegal_o}) && (valid_o == (wr_en_o || illegal_o))); // R12
  AST_PLAIN_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && !neg_i) |=> (res_o[RES_W-1:1] == '0));                // R4
  AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && neg_i) |=> (res_o == '0 || res_o == '1));             // R6
endmodule

bind cbs_setter cbs_setter_chk #(.RES_W(RES_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .en_i      (en_i),
  .neg_i     (neg_i),
  .res_o     (res_o),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o),
  .valid_o   (valid_o)
);

// File: tb/tb_cbs_setter.sv
module tb_cbs_setter;
  localparam logic [63:0] ONES = {64{1'b1}};
  localparam logic [63:0] ONE  = 64'd1;
  localparam logic [63:0] ZERO = 64'd0;
  localparam int NVEC = 12;

  // {cr, idx, neg, rev, en, expected}
  localparam logic [103:0] VEC [NVEC] = '{
    {32'h8000_0000, 5'd0,  1'b0, 1'b0, 1'b1, ONE },  // R2 R3 R4
    {32'h8000_0000, 5'd1,  1'b0, 1'b0, 1'b1, ZERO},  // R3 R4
    {32'h0000_0001, 5'd31, 1'b0, 1'b0, 1'b1, ONE },  // R2 R3
    {32'h0000_0001, 5'd31, 1'b0, 1'b1, 1'b1, ZERO},  // R5
    {32'h0000_0000, 5'd5,  1'b0, 1'b1, 1'b1, ONE },  // R5
    {32'h0400_0000, 5'd5,  1'b1, 1'b0, 1'b1, ONES},  // R6
    {32'h0400_0000, 5'd4,  1'b1, 1'b0, 1'b1, ZERO},  // R6 R3
    {32'hFFFF_FFFF, 5'd13, 1'b1, 1'b1, 1'b1, ZERO},  // R7
    {32'hFFFF_DFFF, 5'd18, 1'b1, 1'b1, 1'b1, ONES},  // R7 R11
    {32'h0000_0010, 5'd27, 1'b0, 1'b0, 1'b1, ONE },  // R2 R4
    {32'hFFFF_FFEF, 5'd27, 1'b0, 1'b0, 1'b1, ZERO},  // R11
    {32'h0010_0000, 5'd11, 1'b1, 1'b0, 1'b1, ONES}   // R6 R2
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] cr_i = '0;
  logic [4:0]  bit_idx_i = '0;
  logic        neg_i = 1'b0;
  logic        rev_i = 1'b0;
  logic [63:0] res_o;
  logic        wr_en_o;
  logic        illegal_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  cbs_setter dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .en_i      (en_i),
    .cr_i      (cr_i),
    .bit_idx_i (bit_idx_i),
    .neg_i     (neg_i),
    .rev_i     (rev_i),
    .res_o     (res_o),
    .wr_en_o   (wr_en_o),
    .illegal_o (illegal_o),
    .valid_o   (valid_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] cr, input logic [4:0] idx,
                       input logic n, input logic r, input logic e);
    @(negedge clk_i);
    cr_i = cr; bit_idx_i = idx; neg_i = n; rev_i = r; en_i = e; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 valid in reset", {63'd0, valid_o}, ZERO);
    chk("R1 wr_en in reset", {63'd0, wr_en_o}, ZERO);
    chk("R1 res in reset", res_o, ZERO);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][103:72], VEC[i][71:67], VEC[i][66], VEC[i][65], VEC[i][64]);
      chk($sformatf("R2-vector%0d res", i), res_o, VEC[i][63:0]);
      chk($sformatf("R8 vector%0d valid", i), {63'd0, valid_o}, ONE);
      chk($sformatf("R12 vector%0d wr_en", i), {62'd0, wr_en_o, illegal_o}, 64'd2);
    end

    // idle after request
    @(negedge clk_i);
    chk("R10 idle valid", {63'd0, valid_o}, ZERO);
    chk("R10 idle res", res_o, ZERO);

    // disabled feature
    issue(32'hFFFF_FFFF, 5'd0, 1'b1, 1'b0, 1'b0);
    chk("R9 illegal flag", {62'd0, illegal_o, wr_en_o}, 64'd2);
    chk("R9 res zero", res_o, ZERO);
    chk("R12 valid on illegal", {63'd0, valid_o}, ONE);

    // back-to-back requests
    @(negedge clk_i);
    cr_i = 32'h0800_0000; bit_idx_i = 5'd4; neg_i = 1'b0; rev_i = 1'b0;
    en_i = 1'b1; req_i = 1'b1;
    @(negedge clk_i);
    chk("R8 b2b first", res_o, ONE);
    bit_idx_i = 5'd3;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R8 b2b second", res_o, ZERO);
    chk("R8 b2b valid", {63'd0, valid_o}, ONE);

    // asynchronous reset clears a pending result
    issue(32'h8000_0000, 5'd0, 1'b1, 1'b0, 1'b1);
    chk("R6 pre-reset", res_o, ONES);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async res", res_o, ZERO);
    chk("R1 async valid", {63'd0, valid_o}, ZERO);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule